// File: doc/BRIEF.md
# Pin-Change Interrupt Unit

This block produces the interrupt request for a small I/O port. Each port pin passes through a two-stage synchronizer. It is then tested against one of two trigger conditions, chosen per pin. In change mode the pin fires when its synchronized value differs from the value sampled on the previous cycle. In compare mode it fires for as long as the value differs from a programmed reference bit. A per-pin enable gates both conditions.

When a trigger is seen and no interrupt is pending, the unit does three things. It raises exactly one bit in a flag vector, for the lowest-numbered pin that fired. It takes a snapshot of the whole synchronized port. It asserts the interrupt output. Flag and snapshot then stay frozen until a clear. The clear comes from a read strobe, and a configuration bit picks which strobe counts: a read of the live port or a read of the snapshot.

The interrupt output can be driven push-pull with either polarity, or as open drain. Open drain overrides the polarity setting. All control and status pins are plain level signals. The block has no data stream, so no valid/ready handshake is needed.

Top module: `pcint_unit`

## Requirements
- R1: After reset the flag vector and the snapshot are all zero. In push-pull mode the interrupt output shows the inactive level for the selected polarity.
- R2: A pin whose enable bit is 0 never sets a flag bit, whatever its value does.
- R3: A pin with mode bit 0 fires when its synchronized value differs from the value sampled one cycle earlier. A level change on the pin input shows in the flag vector after the third rising clock edge, and not after the second.
- R4: A pin with mode bit 1 fires while its synchronized value differs from its reference bit. Once the values agree, no new flag is raised for that pin.
- R5: When several enabled pins fire in the same cycle, only the bit of the lowest-numbered one is set. The flag vector never has more than one bit set.
- R6: The snapshot output takes the synchronized port value of the cycle in which the flag is raised.
- R7: While a flag is pending and no clear occurs, the flag vector and the snapshot do not change, whatever the pins do.
- R8: With the clear-source bit at 0, a port-read strobe clears the pending flag and a snapshot-read strobe is ignored. With the bit at 1 the roles swap. The flag is zero after the edge that samples the strobe.
- R9: In compare mode, a mismatch that still exists after a clear raises the flag again on the next rising edge.
- R10: In push-pull mode (open-drain bit 0), the output enable is 1 and the driven level equals the pending state when the polarity bit is 1, or its inverse when the polarity bit is 0. In open-drain mode the driven level is 0 and the output enable equals the pending state.
- R11: A change-mode pin that toggles while a flag is pending is flagged on the first edge after the clear, because the previous-value register stays frozen while a flag is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_in | input | N | Raw port pin levels |
| en_mask | input | N | Per-pin interrupt enable |
| mode_mask | input | N | Per-pin mode: 1 compare with reference, 0 change |
| ref_val | input | N | Reference bits for compare mode |
| ctl_clr_on_cap | input | 1 | Clear source: 1 snapshot read, 0 port read |
| ctl_act_high | input | 1 | Push-pull polarity: 1 active high |
| ctl_open_drain | input | 1 | Open-drain output, overrides polarity |
| rd_port_stb | input | 1 | One-cycle strobe: live port is being read |
| rd_cap_stb | input | 1 | One-cycle strobe: snapshot is being read |
| flag_o | output | N | One-hot pin that raised the pending interrupt |
| cap_o | output | N | Port snapshot taken when the flag was raised |
| int_drv | output | 1 | Level driven on the interrupt pin |
| int_oe | output | 1 | Output enable of the interrupt pin |

## Verification
A pin edge applied between clock edges reaches the flag and snapshot after the third rising edge: two synchronizer stages, then the flag register. The bench samples one falling edge after the second edge to confirm the flag is still clear, and again after the third to see it set. Changes to enables, modes or reference bits act on the very next edge, because they feed the comparison combinationally. A clear strobe takes effect on the edge that samples it, and a compare-mode re-assertion follows one edge later. The interrupt pins follow the flag register with no extra delay, so they are checked in the same falling-edge sample as the flag. A bench model advances at each rising edge, and every comparison is made at the falling edge, away from the edge the design switches on.

// File: rtl/pcint_pkg.sv
package pcint_pkg;
  localparam int unsigned PCINT_PINS = 8;

  typedef enum logic {
    CLR_ON_PORT = 1'b0,
    CLR_ON_CAP  = 1'b1
  } pcint_clr_e;
endpackage

// File: rtl/pcint_sync.sv
module pcint_sync #(
  parameter int unsigned N      = pcint_pkg::PCINT_PINS,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] d_in,
  output logic [N-1:0] q_out
);
  logic [N-1:0] stage_q [STAGES];

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          stage_q[g] <= '0;
        end else begin
          stage_q[g] <= (g == 0) ? d_in : stage_q[(g == 0) ? 0 : g-1];
        end
      end
    end
  endgenerate

  assign q_out = stage_q[STAGES-1];
endmodule

// File: rtl/pcint_detect.sv
module pcint_detect #(
  parameter int unsigned N = pcint_pkg::PCINT_PINS
) (
  input  logic [N-1:0] cur,
  input  logic [N-1:0] prev,
  input  logic [N-1:0] en_mask,
  input  logic [N-1:0] mode_mask,
  input  logic [N-1:0] ref_val,
  output logic [N-1:0] first_hit,
  output logic         any_hit
);
  logic [N-1:0] hit;

  genvar g;
  generate
    for (g = 0; g < N; g++) begin : g_pin
      assign hit[g] = en_mask[g] & (mode_mask[g] ? (cur[g] ^ ref_val[g])
                                                 : (cur[g] ^ prev[g]));
    end
  endgenerate

  // lowest-numbered pin wins
  always_comb begin
    first_hit = '0;
    for (int i = N-1; i >= 0; i--) begin
      if (hit[i]) first_hit = N'(1) << i;
    end
  end

  assign any_hit = |hit;
endmodule

// File: rtl/pcint_capture.sv
module pcint_capture #(
  parameter int unsigned N = pcint_pkg::PCINT_PINS
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] cur,
  input  logic [N-1:0] first_hit,
  input  logic         any_hit,
  input  logic         clr,
  output logic [N-1:0] prev,
  output logic [N-1:0] flag_q,
  output logic [N-1:0] cap_q,
  output logic         pending
);
  assign pending = |flag_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= '0;
      cap_q  <= '0;
      prev   <= '0;
    end else begin
      if (!pending) prev <= cur;
      if (pending) begin
        if (clr) flag_q <= '0;
      end else if (any_hit) begin
        flag_q <= first_hit;
        cap_q  <= cur;
      end
    end
  end
endmodule

// File: rtl/pcint_drive.sv
module pcint_drive (
  input  logic pending,
  input  logic act_high,
  input  logic open_drain,
  output logic int_drv,
  output logic int_oe
);
  always_comb begin
    if (open_drain) begin
      int_drv = 1'b0;
      int_oe  = pending;
    end else begin
      int_drv = act_high ? pending : ~pending;
      int_oe  = 1'b1;
    end
  end
endmodule

// File: rtl/pcint_unit.sv
module pcint_unit #(
  parameter int unsigned N = pcint_pkg::PCINT_PINS
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] pin_in,
  input  logic [N-1:0] en_mask,
  input  logic [N-1:0] mode_mask,
  input  logic [N-1:0] ref_val,
  input  logic         ctl_clr_on_cap,
  input  logic         ctl_act_high,
  input  logic         ctl_open_drain,
  input  logic         rd_port_stb,
  input  logic         rd_cap_stb,
  output logic [N-1:0] flag_o,
  output logic [N-1:0] cap_o,
  output logic         int_drv,
  output logic         int_oe
);
  import pcint_pkg::*;

  logic [N-1:0] cur;
  logic [N-1:0] prev;
  logic [N-1:0] first_hit;
  logic         any_hit;
  logic         pending;
  logic         clr;
  pcint_clr_e   clr_src;

  assign clr_src = pcint_clr_e'(ctl_clr_on_cap);
  assign clr     = (clr_src == CLR_ON_CAP) ? rd_cap_stb : rd_port_stb;

  pcint_sync #(.N(N), .STAGES(2)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d_in (pin_in),
    .q_out(cur)
  );

  pcint_detect #(.N(N)) u_detect (
    .cur      (cur),
    .prev     (prev),
    .en_mask  (en_mask),
    .mode_mask(mode_mask),
    .ref_val  (ref_val),
    .first_hit(first_hit),
    .any_hit  (any_hit)
  );

  pcint_capture #(.N(N)) u_capture (
    .clk      (clk),
    .rst_n    (rst_n),
    .cur      (cur),
    .first_hit(first_hit),
    .any_hit  (any_hit),
    .clr      (clr),
    .prev     (prev),
    .flag_q   (flag_o),
    .cap_q    (cap_o),
    .pending  (pending)
  );

  pcint_drive u_drive (
    .pending   (pending),
    .act_high  (ctl_act_high),
    .open_drain(ctl_open_drain),
    .int_drv   (int_drv),
    .int_oe    (int_oe)
  );
endmodule

// File: rtl/pcint_unit_chk.sv
module pcint_unit_chk #(
  parameter int unsigned N = pcint_pkg::PCINT_PINS
) (
  input logic         clk,
  input logic         rst_n,
  input logic [N-1:0] en_mask,
  input logic         ctl_clr_on_cap,
  input logic         ctl_act_high,
  input logic         ctl_open_drain,
  input logic         rd_port_stb,
  input logic         rd_cap_stb,
  input logic [N-1:0] flag_o,
  input logic [N-1:0] cap_o,
  input logic         int_drv,
  input logic         int_oe
);
  logic clr_now;
  assign clr_now = ctl_clr_on_cap ? rd_cap_stb : rd_port_stb;

  // R5: at most one flag bit
  p_flag_onehot_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(flag_o));

  // R2: a newly raised flag belongs to an enabled pin
  p_flag_enabled_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(|flag_o) |-> ((flag_o & $past(en_mask)) != '0));

  // R7: pending state frozen without a clear
  p_hold_pending_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((|flag_o) && !clr_now) |=> ($stable(flag_o) && $stable(cap_o)));

  // R8: selected strobe clears
  p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ((|flag_o) && clr_now) |=> (flag_o == '0));

  // R10: push-pull pin level
  p_push_pull_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_open_drain |-> (int_oe && (int_drv == ((|flag_o) == ctl_act_high))));

  // R10: open-drain pin
  p_open_drain_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_open_drain |-> (!int_drv && (int_oe == (|flag_o))));
endmodule

bind pcint_unit pcint_unit_chk #(.N(N)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .en_mask       (en_mask),
  .ctl_clr_on_cap(ctl_clr_on_cap),
  .ctl_act_high  (ctl_act_high),
  .ctl_open_drain(ctl_open_drain),
  .rd_port_stb   (rd_port_stb),
  .rd_cap_stb    (rd_cap_stb),
  .flag_o        (flag_o),
  .cap_o         (cap_o),
  .int_drv       (int_drv),
  .int_oe        (int_oe)
);

// File: tb/pcint_unit_tb.sv
module pcint_unit_tb;
  localparam int N = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] pin_in = '0, en_mask = '0, mode_mask = '0, ref_val = '0;
  logic         ctl_clr_on_cap = 1'b0, ctl_act_high = 1'b0, ctl_open_drain = 1'b0;
  logic         rd_port_stb = 1'b0, rd_cap_stb = 1'b0;
  logic [N-1:0] flag_o, cap_o;
  logic         int_drv, int_oe;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  bit model_cmp = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  pcint_unit #(.N(N)) u_dut (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .en_mask(en_mask),
    .mode_mask(mode_mask), .ref_val(ref_val), .ctl_clr_on_cap(ctl_clr_on_cap),
    .ctl_act_high(ctl_act_high), .ctl_open_drain(ctl_open_drain),
    .rd_port_stb(rd_port_stb), .rd_cap_stb(rd_cap_stb),
    .flag_o(flag_o), .cap_o(cap_o), .int_drv(int_drv), .int_oe(int_oe)
  );

  // reference model built from the requirements
  logic [N-1:0] m_s1, m_s2, m_prev, m_flag, m_cap;

  function automatic logic [N-1:0] lowest_bit(logic [N-1:0] v);
    for (int i = 0; i < N; i++) if (v[i]) return N'(1) << i;
    return '0;
  endfunction

  function automatic logic [N-1:0] model_hits(logic [N-1:0] cur, logic [N-1:0] prv);
    return en_mask & ((mode_mask & (cur ^ ref_val)) | (~mode_mask & (cur ^ prv)));
  endfunction

  function automatic logic [1:0] model_pin(logic pend);
    if (ctl_open_drain) return {1'b0, pend};
    return {(ctl_act_high ? pend : ~pend), 1'b1};
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s1 <= '0; m_s2 <= '0; m_prev <= '0; m_flag <= '0; m_cap <= '0;
    end else begin
      logic [N-1:0] h;
      logic clr;
      h   = model_hits(m_s2, m_prev);
      clr = ctl_clr_on_cap ? rd_cap_stb : rd_port_stb;
      if (|m_flag) begin
        if (clr) m_flag <= '0;
      end else begin
        m_prev <= m_s2;
        if (|h) begin
          m_flag <= lowest_bit(h);
          m_cap  <= m_s2;
        end
      end
      m_s2 <= m_s1;
      m_s1 <= pin_in;
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_port();
    rd_port_stb = 1'b1; step(); rd_port_stb = 1'b0;
  endtask

  task automatic pulse_cap();
    rd_cap_stb = 1'b1; step(); rd_cap_stb = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  always @(negedge clk) begin
    if (model_cmp && rst_n) begin
      logic [1:0] p;
      p = model_pin(|m_flag);
      chk("R5 flag (random)", 32'(flag_o), 32'(m_flag));
      chk("R6 snapshot (random)", 32'(cap_o), 32'(m_cap));
      chk("R10 pin level (random)", 32'(int_drv), 32'(p[1]));
      chk("R10 pin enable (random)", 32'(int_oe), 32'(p[0]));
    end
  end

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    void'($urandom(32'd20240611));
    step(3);
    rst_n = 1'b1;
    step();
    // R1
    chk("R1 flag", 32'(flag_o), 0);
    chk("R1 snapshot", 32'(cap_o), 0);
    chk("R1 inactive low-polarity level", 32'(int_drv), 1);
    chk("R1 enable", 32'(int_oe), 1);

    // R2: disabled pin toggles
    en_mask = 8'h01;
    pin_in = 8'h08;
    step(4);
    chk("R2 disabled pin", 32'(flag_o), 0);

    // R3: latency of change mode
    pin_in = 8'h09;
    step(2);
    chk("R3 not after second edge", 32'(flag_o), 0);
    step();
    chk("R3 flag after third edge", 32'(flag_o), 32'h01);
    chk("R6 snapshot", 32'(cap_o), 32'h09);
    chk("R10 active low asserted", 32'(int_drv), 0);

    // R7: pending freezes
    en_mask = 8'hFF;
    pin_in = 8'h0F;
    step(4);
    chk("R7 flag frozen", 32'(flag_o), 32'h01);
    chk("R7 snapshot frozen", 32'(cap_o), 32'h09);

    // R8: wrong strobe ignored, right one clears
    pulse_cap();
    chk("R8 snapshot read ignored", 32'(flag_o), 32'h01);
    pulse_port();
    chk("R8 port read clears", 32'(flag_o), 0);

    // R11: change during pending reported after clear
    step();
    chk("R11 deferred change", 32'(flag_o), 32'h02);
    chk("R11 snapshot", 32'(cap_o), 32'h0F);
    pulse_port();
    step(3);
    chk("R11 no spurious flag", 32'(flag_o), 0);

    // R5: simultaneous pins 2 and 5
    pin_in = 8'h2B;
    step(3);
    chk("R5 lowest pin wins", 32'(flag_o), 32'h04);
    chk("R6 snapshot", 32'(cap_o), 32'h2B);
    pulse_port();
    step(2);

    // R4 / R9: compare mode on pin 6, reference 1
    ctl_clr_on_cap = 1'b1;
    ctl_act_high = 1'b1;
    mode_mask = 8'h40;
    ref_val = 8'h40;
    step();
    chk("R4 mismatch flags", 32'(flag_o), 32'h40);
    chk("R10 active high asserted", 32'(int_drv), 1);
    pulse_port();
    chk("R8 port read ignored", 32'(flag_o), 32'h40);
    pulse_cap();
    chk("R8 snapshot read clears", 32'(flag_o), 0);
    step();
    chk("R9 re-assert next edge", 32'(flag_o), 32'h40);
    pin_in = 8'h6B;
    step(2);
    pulse_cap();
    step(2);
    chk("R4 match stays clear", 32'(flag_o), 0);

    // R10: open drain
    ctl_open_drain = 1'b1;
    ref_val = 8'h00;
    step();
    chk("R10 open drain flag", 32'(flag_o), 32'h40);
    chk("R10 open drain enable on", 32'(int_oe), 1);
    chk("R10 open drain level", 32'(int_drv), 0);
    en_mask = 8'h00;
    pulse_cap();
    chk("R10 open drain released", 32'(int_oe), 0);
    step();
    chk("R2 disabled compare pin", 32'(flag_o), 0);

    // constrained random against the model
    model_cmp = 1'b1;
    for (int c = 0; c < 4000; c++) begin
      if (c % 250 == 0) begin
        en_mask = 8'($urandom);
        mode_mask = 8'($urandom) & 8'($urandom);
        ref_val = 8'($urandom);
        ctl_clr_on_cap = 1'($urandom);
        ctl_act_high = 1'($urandom);
        ctl_open_drain = 1'($urandom);
      end
      if ($urandom_range(0, 5) == 0) pin_in[$urandom_range(0, N-1)] ^= 1'b1;
      if ($urandom_range(0, 15) == 0) pin_in ^= 8'($urandom);
      rd_port_stb = ($urandom_range(0, 9) == 0);
      rd_cap_stb  = ($urandom_range(0, 9) == 0);
      step();
    end
    rd_port_stb = 1'b0;
    rd_cap_stb = 1'b0;
    model_cmp = 1'b0;
    finish_run();
  end
endmodule